// File: doc/BRIEF.md
# Converter Core Start-up Sequencer

This block brings the digital core of a multichannel audio converter out of reset. It runs on the master clock. While the active-low reset is held, every configuration setting sits at its default and both converter sections are held powered down. Once reset is released, a fixed-length start-up pass runs. It first drives a write strobe with zero data across every address of the internal sample memory. It then waits out the rest of a fixed master-clock budget before it raises `ready`.

Configuration writes arrive through a small strobe-and-select port. One select powers the playback (DAC) section up or down, another does the same for the capture (ADC) section, and a third sets the master-clock-to-sample-rate ratio. Only the rate setting is time-critical. A rate write is taken only inside an early window counted from reset release. A late write that asks for one of the high ratios sets a sticky warning flag. Until `ready` rises, serial samples are blocked in both directions and the playback frame and bit clocks are held low.

Top module: `core_startup_seq`

## Requirements
- R1: While `rst_n` is low: `ready`=0, `mem_we`=0, `dac_off`=1, `adc_off`=1, `rate_sel`=0, and `late_cfg`=0. Both power-down settings return to 0 (powered up).
- R2: Cycle k is the k-th master clock after reset release, with k=0 the cycle before the first rising edge. For k < MEM_DEPTH, `mem_we`=1, `mem_addr`=k and `mem_wdata`=0. From k = MEM_DEPTH on, `mem_we`=0.
- R3: `ready` is 0 for cycles k < INIT_CYCLES. It is 1 from cycle k = INIT_CYCLES and stays 1 until the next reset.
- R4: A write with `cfg_sel`=0 stores `cfg_data[0]` as the DAC power-down bit, and `cfg_sel`=1 stores it as the ADC power-down bit. The new value is visible from the next cycle. `dac_off` = !ready | DAC bit, and `adc_off` = !ready | ADC bit. Such writes leave `rate_sel` and the other section's bit unchanged.
- R5: A write with `cfg_sel`=2 stores `cfg_data` into `rate_sel` only when it is clocked in at cycle k < CFG_WINDOW. A later write leaves `rate_sel` unchanged. The codes are 0 = 256x, 1 = 512x, 2 = 768x and 3 = reserved. A write with `cfg_sel`=3 changes nothing.
- R6: A `cfg_sel`=2 write clocked in at k >= CFG_WINDOW with `cfg_data` equal to 1 or 2 sets `late_cfg` from the next cycle. The flag stays set until reset. A late write of 0 or 3 does not set it.
- R7: While `ready`=0, `core_in`, `core_in_vld` and `ser_out` are 0. While `ready`=1, `core_in`=`ser_in`, `core_in_vld`=`ser_in_vld` and `ser_out`=`core_out`.
- R8: While `ready`=0, `dac_lrclk_out` and `dac_bclk_out` are 0. While `ready`=1, they follow `dac_lrclk_in` and `dac_bclk_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 DAC power-down, 1 ADC power-down, 2 rate, 3 none |
| cfg_data | input | 2 | Write value |
| ser_in | input | DATA_W | Serial-port sample toward the core |
| ser_in_vld | input | 1 | Valid for ser_in |
| core_out | input | DATA_W | Core sample toward the serial port |
| dac_lrclk_in | input | 1 | Playback frame clock from the pins |
| dac_bclk_in | input | 1 | Playback bit clock from the pins |
| mem_we | output | 1 | Sample memory clear write strobe |
| mem_addr | output | ADDR_W | Sample memory clear address |
| mem_wdata | output | DATA_W | Clear data (zero) |
| ready | output | 1 | Start-up complete |
| dac_off | output | 1 | Playback digital section stopped |
| adc_off | output | 1 | Capture digital section stopped |
| rate_sel | output | 2 | Clock ratio setting |
| late_cfg | output | 1 | Sticky late rate-write warning |
| core_in | output | DATA_W | Gated sample into the core |
| core_in_vld | output | 1 | Gated valid into the core |
| ser_out | output | DATA_W | Gated sample to the serial port |
| dac_lrclk_out | output | 1 | Gated playback frame clock |
| dac_bclk_out | output | 1 | Gated playback bit clock |

## Verification
The bench uses the full budget of 4500 cycles and the early window of 3072 cycles, so both boundaries are crossed at their real values. The memory depth is set to 1000. Because that is not a power of two, the clear pass must stop on an end count rather than on an address wrap. It also leaves a long stretch between the end of the clear and `ready` where neither event is active. With a 16-bit sample width, the bench can drive distinct data on every cycle, so any leak past the gate shows up in the comparison.

// File: rtl/startup_pkg.sv
package startup_pkg;

   typedef enum logic [1:0] {
      SEL_DAC_PD = 2'd0,
      SEL_ADC_PD = 2'd1,
      SEL_RATE   = 2'd2,
      SEL_NONE   = 2'd3
   } cfg_sel_e;

   typedef enum logic [1:0] {
      RATE_256  = 2'd0,
      RATE_512  = 2'd1,
      RATE_768  = 2'd2,
      RATE_RSVD = 2'd3
   } rate_e;

   function automatic logic rate_needs_early(input logic [1:0] code);
      return (code == RATE_512) || (code == RATE_768);
   endfunction

endpackage

// File: rtl/su_cycle_counter.sv
module su_cycle_counter #(
   parameter int INIT_CYCLES = 4500,
   parameter int CFG_WINDOW  = 3072
) (
   input  logic clk,
   input  logic rst_n,
   output logic ready,
   output logic in_window
);
   localparam int CNT_W = $clog2(INIT_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_CYCLES);
   localparam logic [CNT_W-1:0] WIN  = CNT_W'(CFG_WINDOW);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign ready     = (cnt_q == LAST);
   assign in_window = (cnt_q < WIN);

   // R3: once raised, ready never drops until reset
   p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

endmodule

// File: rtl/su_clear_gen.sv
module su_clear_gen #(
   parameter int MEM_DEPTH = 1024,
   parameter int ADDR_W    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr
);
   localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(MEM_DEPTH - 1);

   logic              active_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b1;
         addr_q   <= '0;
      end else if (active_q) begin
         if (addr_q == END_ADDR) active_q <= 1'b0;
         else                    addr_q   <= addr_q + 1'b1;
      end
   end

   assign mem_we   = active_q & rst_n;
   assign mem_addr = addr_q;

   // R2: consecutive strobes walk the address by one
   p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

endmodule

// File: rtl/su_cfg_regs.sv
module su_cfg_regs
   import startup_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_wr,
   input  logic [1:0] cfg_sel,
   input  logic [1:0] cfg_data,
   input  logic       in_window,
   output logic       dac_pd,
   output logic       adc_pd,
   output logic [1:0] rate,
   output logic       late_cfg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_pd   <= 1'b0;
         adc_pd   <= 1'b0;
         rate     <= RATE_256;
         late_cfg <= 1'b0;
      end else if (cfg_wr) begin
         case (cfg_sel_e'(cfg_sel))
            SEL_DAC_PD: dac_pd <= cfg_data[0];
            SEL_ADC_PD: adc_pd <= cfg_data[0];
            SEL_RATE: begin
               if (in_window)                   rate     <= cfg_data;
               else if (rate_needs_early(cfg_data)) late_cfg <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   // R5: the rate only moves in response to a write inside the window
   p_rate_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rate) |-> $past(in_window) && $past(cfg_wr));
   // R6: the warning is sticky
   p_late_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      late_cfg |=> late_cfg);
   // R4: power-down writes leave the rate setting alone
   p_pd_keeps_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_wr) && ($past(cfg_sel) != SEL_RATE)) |-> $stable(rate));

endmodule

// File: rtl/su_sample_gate.sv
module su_sample_gate #(
   parameter int DATA_W        = 24,
   parameter bit HOLD_DAC_CLKS = 1'b1
) (
   input  logic              ready,
   input  logic [DATA_W-1:0] ser_in,
   input  logic              ser_in_vld,
   input  logic [DATA_W-1:0] core_out,
   input  logic              lr_in,
   input  logic              bclk_in,
   output logic [DATA_W-1:0] core_in,
   output logic              core_in_vld,
   output logic [DATA_W-1:0] ser_out,
   output logic              lr_out,
   output logic              bclk_out
);
   assign core_in     = ready ? ser_in : '0;
   assign core_in_vld = ready & ser_in_vld;
   assign ser_out     = ready ? core_out : '0;

   generate
      if (HOLD_DAC_CLKS) begin : g_hold
         assign lr_out   = ready & lr_in;
         assign bclk_out = ready & bclk_in;
      end else begin : g_pass
         assign lr_out   = lr_in;
         assign bclk_out = bclk_in;
      end
   endgenerate

endmodule

// File: rtl/core_startup_seq.sv
module core_startup_seq #(
   parameter int INIT_CYCLES   = 4500,
   parameter int CFG_WINDOW    = 3072,
   parameter int MEM_DEPTH     = 1024,
   parameter int DATA_W        = 24,
   parameter bit HOLD_DAC_CLKS = 1'b1,
   localparam int ADDR_W       = $clog2(MEM_DEPTH)
) (
   input  logic              clk_mclk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [1:0]        cfg_data,
   input  logic [DATA_W-1:0] ser_in,
   input  logic              ser_in_vld,
   input  logic [DATA_W-1:0] core_out,
   input  logic              dac_lrclk_in,
   input  logic              dac_bclk_in,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              ready,
   output logic              dac_off,
   output logic              adc_off,
   output logic [1:0]        rate_sel,
   output logic              late_cfg,
   output logic [DATA_W-1:0] core_in,
   output logic              core_in_vld,
   output logic [DATA_W-1:0] ser_out,
   output logic              dac_lrclk_out,
   output logic              dac_bclk_out
);
   if (MEM_DEPTH < 2)             begin : g_bad_depth  $error("MEM_DEPTH must be at least 2"); end
   if (MEM_DEPTH > INIT_CYCLES)   begin : g_bad_fit    $error("clear pass exceeds start-up budget"); end
   if (CFG_WINDOW > INIT_CYCLES)  begin : g_bad_window $error("rate window exceeds start-up budget"); end
   if (DATA_W < 1)                begin : g_bad_width  $error("DATA_W must be positive"); end

   logic in_window;
   logic dac_pd, adc_pd;

   su_cycle_counter #(.INIT_CYCLES(INIT_CYCLES), .CFG_WINDOW(CFG_WINDOW)) u_cnt (
      .clk(clk_mclk), .rst_n(rst_n), .ready(ready), .in_window(in_window));

   su_clear_gen #(.MEM_DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)) u_clr (
      .clk(clk_mclk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr));

   su_cfg_regs u_cfg (
      .clk(clk_mclk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .in_window(in_window), .dac_pd(dac_pd),
      .adc_pd(adc_pd), .rate(rate_sel), .late_cfg(late_cfg));

   su_sample_gate #(.DATA_W(DATA_W), .HOLD_DAC_CLKS(HOLD_DAC_CLKS)) u_gate (
      .ready(ready), .ser_in(ser_in), .ser_in_vld(ser_in_vld), .core_out(core_out),
      .lr_in(dac_lrclk_in), .bclk_in(dac_bclk_in), .core_in(core_in),
      .core_in_vld(core_in_vld), .ser_out(ser_out), .lr_out(dac_lrclk_out),
      .bclk_out(dac_bclk_out));

   assign mem_wdata = '0;
   assign dac_off   = ~ready | dac_pd;
   assign adc_off   = ~ready | adc_pd;

   // R2/R3: the clear pass is over before ready is raised
   p_clear_before_ready_r2: assert property (@(posedge clk_mclk) disable iff (!rst_n)
      mem_we |-> !ready);
   // R7: nothing reaches the core before ready
   p_gate_closed_r7: assert property (@(posedge clk_mclk) disable iff (!rst_n)
      !ready |-> !core_in_vld && (ser_out == '0));

endmodule

// File: tb/core_startup_seq_tb.sv
module core_startup_seq_tb;
   localparam int INIT = 4500;
   localparam int WIN  = 3072;
   localparam int DEP  = 1000;
   localparam int DW   = 16;
   localparam int AW   = $clog2(DEP);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [1:0] cfg_sel = 2'd3;
   logic [1:0] cfg_data = 2'd0;
   logic [DW-1:0] ser_in = 16'h1234;
   logic ser_in_vld = 1'b0;
   logic [DW-1:0] core_out = 16'hBEEF;
   logic lr_in = 1'b0, bck_in = 1'b0;

   logic mem_we, ready, dac_off, adc_off, late_cfg, core_in_vld, lr_out, bck_out;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, core_in, ser_out;
   logic [1:0] rate_sel;

   core_startup_seq #(.INIT_CYCLES(INIT), .CFG_WINDOW(WIN), .MEM_DEPTH(DEP), .DATA_W(DW)) u_dut (
      .clk_mclk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .ser_in(ser_in), .ser_in_vld(ser_in_vld), .core_out(core_out),
      .dac_lrclk_in(lr_in), .dac_bclk_in(bck_in), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .ready(ready), .dac_off(dac_off), .adc_off(adc_off),
      .rate_sel(rate_sel), .late_cfg(late_cfg), .core_in(core_in), .core_in_vld(core_in_vld),
      .ser_out(ser_out), .dac_lrclk_out(lr_out), .dac_bclk_out(bck_out));

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   // behavioural model state
   int m_cnt = 0;
   bit m_dac = 0, m_adc = 0, m_late = 0;
   int m_rate = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_dac = 0; m_adc = 0; m_rate = 0; m_late = 0;
      end else begin
         if (cfg_wr) begin
            if (cfg_sel == 2'd0) m_dac = cfg_data[0];
            else if (cfg_sel == 2'd1) m_adc = cfg_data[0];
            else if (cfg_sel == 2'd2) begin
               if (m_cnt < WIN) m_rate = cfg_data;
               else if (cfg_data == 2'd1 || cfg_data == 2'd2) m_late = 1;
            end
         end
         if (m_cnt < INIT) m_cnt++;
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            chk("R1", "ready", ready, 0);
            chk("R1", "mem_we", mem_we, 0);
            chk("R1", "dac_off", dac_off, 1);
            chk("R1", "adc_off", adc_off, 1);
            chk("R1", "rate_sel", rate_sel, 0);
            chk("R1", "late_cfg", late_cfg, 0);
            chk("R7", "core_in_vld", core_in_vld, 0);
            chk("R7", "ser_out", ser_out, 0);
         end else begin
            bit e_rdy;
            e_rdy = (m_cnt == INIT);
            chk("R3", "ready", ready, e_rdy);
            chk("R2", "mem_we", mem_we, m_cnt < DEP);
            if (m_cnt < DEP) begin
               chk("R2", "mem_addr", mem_addr, m_cnt);
               chk("R2", "mem_wdata", mem_wdata, 0);
            end
            chk("R4", "dac_off", dac_off, !e_rdy || m_dac);
            chk("R4", "adc_off", adc_off, !e_rdy || m_adc);
            chk("R5", "rate_sel", rate_sel, m_rate);
            chk("R6", "late_cfg", late_cfg, m_late);
            chk("R7", "core_in", core_in, e_rdy ? ser_in : 0);
            chk("R7", "core_in_vld", core_in_vld, e_rdy && ser_in_vld);
            chk("R7", "ser_out", ser_out, e_rdy ? core_out : 0);
            chk("R8", "dac_lrclk_out", lr_out, e_rdy && lr_in);
            chk("R8", "dac_bclk_out", bck_out, e_rdy && bck_in);
         end
      end
   end

   // changing data and pin clocks, driven just after each rising edge
   always @(posedge clk) begin
      #1;
      ser_in     = ser_in * 16'd5 + 16'd7;
      core_out   = core_out ^ (ser_in << 1);
      ser_in_vld = ser_in[3];
      bck_in     = ~bck_in;
      lr_in      = ser_in[6];
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic at_cycle(input int n);
      while (m_cnt != n) begin @(posedge clk); #1; end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [1:0] dat);
      cfg_wr = 1; cfg_sel = sel; cfg_data = dat;
      @(posedge clk); #1;
      cfg_wr = 0; cfg_sel = 2'd3;
   endtask

   initial begin
      step(5);
      rst_n = 1;
      // run 1: early and late rate writes, power-down toggles (R4 R5 R6)
      at_cycle(100);  wr(2'd2, 2'd1);
      at_cycle(WIN - 1); wr(2'd2, 2'd2);
      wr(2'd2, 2'd0);          // late, low ratio: dropped, no flag
      wr(2'd3, 2'd3);          // no target: ignored
      at_cycle(3100); wr(2'd2, 2'd1);  // late, high ratio: flag
      at_cycle(4000); wr(2'd0, 2'd1);
      at_cycle(INIT);
      step(20);
      wr(2'd1, 2'd1); step(5);
      wr(2'd0, 2'd0); step(5);
      wr(2'd1, 2'd0); step(10);
      // run 2: reset mid-pass restarts everything (R1 R2 R3)
      rst_n = 0; step(3); rst_n = 1;
      at_cycle(2000);
      rst_n = 0; step(2); rst_n = 1;
      at_cycle(WIN - 1); wr(2'd2, 2'd3);
      wr(2'd2, 2'd2);          // first late cycle, 768x: flag
      at_cycle(INIT);
      step(10);
      rst_n = 0; step(3);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule